// File: doc/BRIEF.md
# Register-Mapped GPIO Port with On-Demand Input Sampling

This block controls a bundle of general-purpose pins through a small register bus. Software chooses each pin's direction and drive level, and reads pin levels back. The direction and drive-level registers can be written whole. They can also be changed one bit at a time with atomic clear, set and toggle operations, so no read-modify-write sequence is needed. Each pin also has its own configuration byte, which turns on the pad's input buffer and its pull resistor.

Pin levels reach the input register through a two-stage resynchronizer for each pin. To save power, a resynchronizer is normally clocked only while software is reading the input register. A read in that mode holds the bus ready low for two clocks while the stages fill. A control register can put any pin into continuous sampling. When every pin samples continuously, an input read completes at once with current data.

Top module: `gpio_port`

## Requirements
- R1: Writing the full direction register (offset 0x00) stores the data word. A 1 in bit n drives pad_oe[n] high (output) and a 0 makes pin n an input.
- R2: Writing the full output register (offset 0x10) stores the data word, and pad_out[n] follows bit n.
- R3: Offsets 0x04, 0x08 and 0x0C clear, set and toggle the direction bits whose data bit is 1. Bits whose data bit is 0 keep their value.
- R4: Offsets 0x14, 0x18 and 0x1C clear, set and toggle the output bits whose data bit is 1. Bits whose data bit is 0 keep their value.
- R5: Reads at offsets 0x00 to 0x0C return the direction register, and reads at offsets 0x10 to 0x1C return the output register.
- R6: The input register (offset 0x20) returns pad levels through two flip-flop stages. A write to it changes nothing.
- R7: When any bit of the sampling-control register (offset 0x24) is 0, a read of the input register holds bus_ready low for exactly two cycles. It then returns the pad levels that were present when the read began. The stages of a pin that is not being read and is not sampled continuously hold their value.
- R8: When every sampling-control bit is 1, a read of the input register is ready in its first cycle. It returns pad levels that have been stable for at least two clock edges.
- R9: The configuration byte for pin n sits at offset 0x40+n. Bit 0 is input enable and drives pad_ie[n]; bit 1 is pull enable and drives pad_pull[n]. The byte reads back in bits 1:0.
- R10: A pin whose input-enable bit is 0 reads as 0 in the input register.
- R11: After reset every register is 0, so every pin is an input with no pull, input buffer off and on-demand sampling.
- R12: Every access other than a stalled input read completes in one cycle. Reads of unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_ready is high |
| bus_ready | output | 1 | Access completes at the clock edge while high |
| pad_in | input | 32 | Raw pad levels |
| pad_oe | output | 32 | Pad output enable per pin |
| pad_out | output | 32 | Pad output level per pin |
| pad_ie | output | 32 | Pad input buffer enable per pin |
| pad_pull | output | 32 | Pad pull resistor enable per pin |

## Verification
On-demand filling and continuous sampling can act on different pins in the same cycle. This happens when the sampling-control register mixes ones and zeros and an input read arrives just after every pad has changed level. The bench sets half the pins to continuous sampling, changes all pads, and issues an input read straight away. It expects a stall of exactly two cycles and the new level on every pin, from both groups. It also checks that clearing a pin's input-enable bit masks that pin in the same read path.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned GP_ADDR_W = 8;

    localparam logic [GP_ADDR_W-1:0] OFS_DIR_BASE = 8'h00;
    localparam logic [GP_ADDR_W-1:0] OFS_OUT_BASE = 8'h10;
    localparam logic [GP_ADDR_W-1:0] OFS_IN       = 8'h20;
    localparam logic [GP_ADDR_W-1:0] OFS_SAMPLE   = 8'h24;
    localparam logic [GP_ADDR_W-1:0] OFS_CFG_BASE = 8'h40;

    // Alias selected by address bits [3:2] inside a 16-byte register group
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_SET    = 2'd2,
        OP_TOGGLE = 2'd3
    } reg_op_e;

    typedef struct packed {
        logic pull_en;
        logic in_en;
    } pin_cfg_t;

    function automatic logic [31:0] apply_op(input reg_op_e op,
                                             input logic [31:0] cur,
                                             input logic [31:0] wd);
        case (op)
            OP_WRITE:  return wd;
            OP_CLEAR:  return cur & ~wd;
            OP_SET:    return cur | wd;
            default:   return cur ^ wd;
        endcase
    endfunction

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_op_e          op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    logic [31:0] next_full;

    always_comb begin
        next_full = apply_op(op, 32'(q), 32'(wdata));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= next_full[WIDTH-1:0];
        end
    end

    // R3 / R4: set alias only raises bits
    a_r3_set_only_raises: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_SET) |=> (q == ($past(q) | $past(wdata))));

    // R3 / R4: toggle alias flips exactly the selected bits
    a_r4_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_TOGGLE) |=> (q == ($past(q) ^ $past(wdata))));

    // R4: no write keeps the value
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] clk_en,
    output logic [NPINS-1:0] synced
);

    logic [NPINS-1:0] stage1;
    logic [NPINS-1:0] stage2;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= 1'b0;
                stage2[i] <= 1'b0;
            end else if (clk_en[i]) begin
                stage1[i] <= pad_in[i];
                stage2[i] <= stage1[i];
            end
        end

        // R7: a gated synchronizer holds its output
        a_r7_gated_holds: assert property (@(posedge clk) disable iff (rst)
            !clk_en[i] |=> $stable(stage2[i]));
    end

    assign synced = stage2;

endmodule

// File: rtl/gpio_read_stall.sv
module gpio_read_stall #(
    parameter int unsigned FILL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_req,
    input  logic need_fill,
    output logic ready
);

    localparam int unsigned CNT_W = $clog2(FILL_CYCLES + 1);

    logic [CNT_W-1:0] wait_cnt;
    logic             filling;

    always_comb begin
        filling = in_req && need_fill;
        ready   = !filling || (wait_cnt == CNT_W'(FILL_CYCLES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
        end else if (filling && !ready) begin
            wait_cnt <= wait_cnt + 1'b1;
        end else begin
            wait_cnt <= '0;
        end
    end

    // R7: after two stalled cycles of a held request, the third is ready
    a_r7_stall_bounded: assert property (@(posedge clk) disable iff (rst)
        (filling && !ready && $past(filling && !ready)) |=> (!filling || ready));

    // R7: the first cycle of an on-demand read is always stalled
    a_r7_first_stalls: assert property (@(posedge clk) disable iff (rst)
        (filling && !$past(filling)) |-> !ready);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = GP_ADDR_W,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_ie,
    output logic [NPINS-1:0]  pad_pull
);

    localparam int unsigned IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

    logic [NPINS-1:0] dir_q, out_q, sample_q, synced, sync_en;
    logic             hit_dir, hit_out, hit_in, hit_sample, hit_cfg;
    logic             in_req, wr_fire;
    reg_op_e          op;
    logic [ADDR_W-1:0] cfg_ofs;
    logic [IDX_W-1:0]  cfg_idx;
    pin_cfg_t          cfg_q [NPINS];

    always_comb begin
        hit_dir    = (bus_addr[ADDR_W-1:4] == OFS_DIR_BASE[ADDR_W-1:4]) && (bus_addr[1:0] == 2'b00);
        hit_out    = (bus_addr[ADDR_W-1:4] == OFS_OUT_BASE[ADDR_W-1:4]) && (bus_addr[1:0] == 2'b00);
        hit_in     = (bus_addr == OFS_IN);
        hit_sample = (bus_addr == OFS_SAMPLE);
        cfg_ofs    = bus_addr - OFS_CFG_BASE;
        hit_cfg    = (bus_addr >= OFS_CFG_BASE) && (cfg_ofs < ADDR_W'(NPINS));
        cfg_idx    = cfg_ofs[IDX_W-1:0];
        op         = reg_op_e'(bus_addr[3:2]);
        in_req     = bus_valid && !bus_write && hit_in;
        wr_fire    = bus_valid && bus_write;
    end

    gpio_alias_reg #(.WIDTH(NPINS)) u_dir (
        .clk(clk), .rst(rst), .wr_en(wr_fire && hit_dir), .op(op),
        .wdata(bus_wdata[NPINS-1:0]), .q(dir_q)
    );

    gpio_alias_reg #(.WIDTH(NPINS)) u_out (
        .clk(clk), .rst(rst), .wr_en(wr_fire && hit_out), .op(op),
        .wdata(bus_wdata[NPINS-1:0]), .q(out_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
        end else if (wr_fire && hit_sample) begin
            sample_q <= bus_wdata[NPINS-1:0];
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (wr_fire && hit_cfg && (cfg_idx == IDX_W'(i))) begin
                cfg_q[i] <= pin_cfg_t'(bus_wdata[1:0]);
            end
        end
        assign pad_ie[i]   = cfg_q[i].in_en;
        assign pad_pull[i] = cfg_q[i].pull_en;
    end

    assign sync_en = sample_q | {NPINS{in_req}};

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst(rst), .pad_in(pad_in), .clk_en(sync_en), .synced(synced)
    );

    gpio_read_stall #(.FILL_CYCLES(2)) u_stall (
        .clk(clk), .rst(rst), .in_req(in_req), .need_fill(!(&sample_q)),
        .ready(bus_ready)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_dir) begin
            bus_rdata = DATA_W'(dir_q);
        end else if (hit_out) begin
            bus_rdata = DATA_W'(out_q);
        end else if (hit_in) begin
            bus_rdata = DATA_W'(synced & pad_ie);
        end else if (hit_sample) begin
            bus_rdata = DATA_W'(sample_q);
        end else if (hit_cfg) begin
            bus_rdata = DATA_W'(cfg_q[cfg_idx]);
        end
    end

    assign pad_oe  = dir_q;
    assign pad_out = out_q;

    // R10: pins with the input buffer off never read as 1
    a_r10_ie_masks: assert property (@(posedge clk) disable iff (rst)
        (in_req && bus_ready) |-> ((bus_rdata[NPINS-1:0] & ~pad_ie) == '0));

    // R12: accesses other than input reads never stall
    a_r12_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !in_req) |-> bus_ready);

    // R6: a write to the input offset leaves direction and output untouched
    a_r6_in_write_inert: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && hit_in) |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid, bus_write;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_ready;
    logic [31:0] pad_in, pad_oe, pad_out, pad_ie, pad_pull;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pad_in(pad_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_ie(pad_ie), .pad_pull(pad_pull)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output int stalls);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; stalls = 0;
        #1;
        while (!bus_ready && stalls < 10) begin
            @(negedge clk); #1;
            stalls++;
        end
        d = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d; int s;
        chk("R11 pad_oe", pad_oe, 32'h0);
        chk("R11 pad_out", pad_out, 32'h0);
        chk("R11 pad_ie", pad_ie, 32'h0);
        chk("R11 pad_pull", pad_pull, 32'h0);
        rd(8'h24, d, s); chk("R11 sample ctrl", d, 32'h0);
        rd(8'h45, d, s); chk("R11 cfg pin5", d, 32'h0);
    endtask

    task automatic t_dir();
        logic [31:0] d; int s;
        wr(8'h00, 32'hF0F0_00FF);
        chk("R1 pad_oe after write", pad_oe, 32'hF0F0_00FF);
        wr(8'h08, 32'h0000_FF00);
        chk("R3 set alias", pad_oe, 32'hF0F0_FFFF);
        wr(8'h04, 32'h0F0F_000F);
        chk("R3 clear alias", pad_oe, 32'hF0F0_FFF0);
        wr(8'h0C, 32'hFF00_0000);
        chk("R3 toggle alias", pad_oe, 32'h0FF0_FFF0);
        rd(8'h0C, d, s); chk("R5 dir via alias offset", d, 32'h0FF0_FFF0);
        chk("R12 dir read no stall", 32'(s), 32'd0);
    endtask

    task automatic t_out();
        logic [31:0] d; int s;
        wr(8'h10, 32'h1234_5678);
        chk("R2 pad_out after write", pad_out, 32'h1234_5678);
        wr(8'h18, 32'h8000_0001);
        chk("R4 set alias", pad_out, 32'h9234_5679);
        wr(8'h14, 32'h0000_0078);
        chk("R4 clear alias", pad_out, 32'h9234_5601);
        wr(8'h1C, 32'hFFFF_0000);
        chk("R4 toggle alias", pad_out, 32'h6DCB_5601);
        rd(8'h10, d, s); chk("R5 out read", d, 32'h6DCB_5601);
        chk("R1 dir unaffected by out writes", pad_oe, 32'h0FF0_FFF0);
    endtask

    task automatic t_cfg();
        logic [31:0] d; int s;
        for (int i = 0; i < 32; i++) wr(8'h40 + 8'(i), 32'h1);
        wr(8'h43, 32'h3);
        wr(8'h5F, 32'h2);
        chk("R9 pad_ie", pad_ie, 32'h7FFF_FFFF);
        chk("R9 pad_pull", pad_pull, 32'h8000_0008);
        rd(8'h43, d, s); chk("R9 cfg readback", d, 32'h3);
    endtask

    task automatic t_ondemand();
        logic [31:0] d; int s;
        pad_in = 32'h3C3C_A5A5;
        repeat (4) @(posedge clk);
        rd(8'h20, d, s);
        chk("R7 stall length", 32'(s), 32'd2);
        chk("R7 on-demand value", d, 32'h3C3C_A5A5 & 32'h7FFF_FFFF);
        pad_in = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        rd(8'h20, d, s);
        chk("R10 masked pin31", d, 32'h7FFF_FFFF);
        chk("R6 sync path fresh after idle", 32'(s), 32'd2);
    endtask

    task automatic t_continuous();
        logic [31:0] d; int s;
        wr(8'h5F, 32'h3);
        wr(8'h24, 32'hFFFF_FFFF);
        @(negedge clk); pad_in = 32'h0F0F_1111;
        repeat (3) @(posedge clk);
        rd(8'h20, d, s);
        chk("R8 no stall", 32'(s), 32'd0);
        chk("R8 continuous value", d, 32'h0F0F_1111);
    endtask

    task automatic t_mixed();
        logic [31:0] d; int s;
        wr(8'h24, 32'h0000_FFFF);
        @(negedge clk); pad_in = 32'hA5A5_5A5A;
        rd(8'h20, d, s);
        chk("R7 mixed stall", 32'(s), 32'd2);
        chk("R7 mixed value", d, 32'hA5A5_5A5A);
    endtask

    task automatic t_ignored();
        logic [31:0] d; int s;
        wr(8'h20, 32'hFFFF_FFFF);
        chk("R6 in write keeps dir", pad_oe, 32'h0FF0_FFF0);
        chk("R6 in write keeps out", pad_out, 32'h6DCB_5601);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h60, 32'hFFFF_FFFF);
        chk("R12 unmapped write keeps oe", pad_oe, 32'h0FF0_FFF0);
        chk("R12 unmapped write keeps ie", pad_ie, 32'hFFFF_FFFF);
        rd(8'h30, d, s); chk("R12 unmapped read", d, 32'h0);
        rd(8'h60, d, s); chk("R12 unmapped read past cfg", d, 32'h0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: got %0d expected under 20000 cycles", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; bus_valid = 1'b0; bus_write = 1'b0;
        bus_addr = '0; bus_wdata = '0; pad_in = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_dir();
        t_out();
        t_cfg();
        t_ondemand();
        t_continuous();
        t_mixed();
        t_ignored();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule